// File: doc/BRIEF.md
# Cache Error Status and Interrupt Unit

This unit sits beside a cache controller and keeps a record of memory-protection faults. The controller pulses one of four event inputs for each fault it sees: a correctable EDAC error, an uncorrectable EDAC error, a write-protection hit, or a backend bus error. All four share one faulting-address bus. The unit keeps a single status slot that holds the kind and address of one fault. It also keeps a per-kind pending vector with its own mask, which drives an interrupt line, and a saturating count of correctable errors.

The slot keeps its contents until software clears it. There is one exception: an uncorrectable EDAC error always replaces whatever the slot holds. The pending bits do not depend on the slot, so a fault that the slot drops still raises its pending bit. Software reaches the state through a small word-addressed register port, where reads are combinational and writes take effect at the clock edge. A lookup input compares an incoming access address with the stored fault address, at 32-byte line granularity, so that the cache can answer that access with an error response.

Top module: `cache_err_log`

## Requirements
- R1: After reset the slot reads as holding an uncorrectable error: STATUS (sel 0) = {cnt[15:8], kind[2:1], valid[0]} with valid=1, kind=1, cnt=0. ADDR (sel 1) reads 0, PEND (sel 2) and MASK (sel 3) read 0, CTRL (sel 4) reads 0, and irq and lk_hit are low.
- R2: An uncorrectable event (kind code 1) always loads the slot with kind 1 and the event address. The load is visible from the cycle after the event, whatever the slot held.
- R3: A correctable (kind 0), write-protection (kind 2) or bus-error (kind 3) event is stored only when the slot is empty. Otherwise the slot's kind and address stay unchanged.
- R4: When several events arrive in one cycle, the slot takes the uncorrectable one first, then correctable, then write-protection, then bus error.
- R5: Writing 1 to CTRL bit 1 empties the slot (valid=0). If an event arrives in the same cycle, the event is stored instead.
- R6: Each event sets its own PEND bit (bit = kind code), whether or not the slot takes it. Writing 1 to a PEND bit clears it, and a same-cycle event keeps the bit set.
- R7: irq is high exactly while some PEND bit is set together with the same MASK bit. MASK is read/write, and 1 enables.
- R8: The correctable count goes up by one for each correctable event and saturates at 255. A slot clear resets it, to 1 if a correctable event arrives in the same cycle.
- R9: lk_hit is high when CTRL bit 0 is set, the slot is valid, and lk_addr[31:5] equals the stored address[31:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ce | input | 1 | Correctable EDAC event pulse |
| ev_ue | input | 1 | Uncorrectable EDAC event pulse |
| ev_wp | input | 1 | Write-protection hit pulse |
| ev_be | input | 1 | Backend bus error pulse |
| ev_addr | input | 32 | Faulting address of this cycle's events |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| lk_addr | input | 32 | Access address to compare with the stored fault |
| lk_hit | output | 1 | Access should receive an error response |

## Verification
A wrong slot state reaches STATUS, ADDR and lk_hit one clock after the event or clear that caused it. A dropped or wrongly overwritten address therefore shows up on the very next read. A wrong pending or mask bit shows at irq in the same cycle as the register change. A counter that wraps instead of saturating shows up as a small count after the 256th correctable event. The sweeps cover every event combination against both an empty and a full slot, with and without a same-cycle clear, so that a wrong priority or a wrong drop decision shows up as a kind or address mismatch.

// File: rtl/cache_err_log_pkg.sv
package cache_err_log_pkg;
  localparam int unsigned N_KINDS = 4;

  typedef enum logic [1:0] {
    K_CE = 2'd0,
    K_UE = 2'd1,
    K_WP = 2'd2,
    K_BE = 2'd3
  } kind_e;

  localparam logic [2:0] SEL_STATUS = 3'd0;
  localparam logic [2:0] SEL_ADDR   = 3'd1;
  localparam logic [2:0] SEL_PEND   = 3'd2;
  localparam logic [2:0] SEL_MASK   = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;

  localparam int unsigned CTRL_RESP_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT  = 1;

  // slot priority: uncorrectable, correctable, write-protect, bus error
  function automatic kind_e pick_kind(input logic [N_KINDS-1:0] ev);
    if (ev[K_UE])      return K_UE;
    else if (ev[K_CE]) return K_CE;
    else if (ev[K_WP]) return K_WP;
    else               return K_BE;
  endfunction
endpackage

// File: rtl/cel_slot.sv
module cel_slot
  import cache_err_log_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_KINDS-1:0] ev,
  input  logic [AW-1:0]      ev_addr,
  input  logic               clr,
  output logic               valid,
  output kind_e              kind,
  output logic [AW-1:0]      addr,
  output logic [CW-1:0]      cnt,
  output logic               take,
  output logic               drop
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic any_ev;
  assign any_ev = |ev;
  assign take   = ev[K_UE] | (any_ev & (~valid | clr));
  assign drop   = any_ev & ~take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b1;
      kind  <= K_UE;
      addr  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      kind  <= pick_kind(ev);
      addr  <= ev_addr;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= ev[K_CE] ? CW'(1) : '0;
    else if (ev[K_CE]) cnt <= sat_inc(cnt);
  end
endmodule

// File: rtl/cel_pend.sv
module cel_pend
  import cache_err_log_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_KINDS-1:0] ev,
  input  logic               w1c_we,
  input  logic [N_KINDS-1:0] w1c_bits,
  input  logic               mask_we,
  input  logic [N_KINDS-1:0] mask_bits,
  output logic [N_KINDS-1:0] pend,
  output logic [N_KINDS-1:0] mask,
  output logic               irq
);
  for (genvar k = 0; k < N_KINDS; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                   pend[k] <= 1'b0;
      else if (ev[k])               pend[k] <= 1'b1;
      else if (w1c_we && w1c_bits[k]) pend[k] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)       mask[k] <= 1'b0;
      else if (mask_we) mask[k] <= mask_bits[k];
    end
  end

  assign irq = |(pend & mask);
endmodule

// File: rtl/cel_match.sv
module cel_match #(
  parameter int unsigned AW  = 32,
  parameter int unsigned OFS = 5
) (
  input  logic          resp_en,
  input  logic          valid,
  input  logic [AW-1:0] slot_addr,
  input  logic [AW-1:0] lk_addr,
  output logic          hit
);
  function automatic logic same_line(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:OFS] == b[AW-1:OFS];
  endfunction

  assign hit = resp_en & valid & same_line(slot_addr, lk_addr);
endmodule

// File: rtl/cache_err_log.sv
module cache_err_log
  import cache_err_log_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LINE_OFS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ce,
  input  logic              ev_ue,
  input  logic              ev_wp,
  input  logic              ev_be,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit
);
  localparam int unsigned CNT_LSB = 8;

  logic [N_KINDS-1:0] ev_vec;
  logic               clr_pulse;
  logic               pend_we;
  logic               mask_we;
  logic               ctrl_we;
  logic               resp_en;
  logic               slot_valid;
  kind_e              slot_kind;
  logic [ADDR_W-1:0]  slot_addr;
  logic [CNT_W-1:0]   slot_cnt;
  logic               slot_take;
  logic               slot_drop;
  logic [N_KINDS-1:0] pend;
  logic [N_KINDS-1:0] mask;
  logic               unused_wdata;

  assign ev_vec = {ev_be, ev_wp, ev_ue, ev_ce};

  assign ctrl_we   = reg_we && (reg_sel == SEL_CTRL);
  assign pend_we   = reg_we && (reg_sel == SEL_PEND);
  assign mask_we   = reg_we && (reg_sel == SEL_MASK);
  assign clr_pulse = ctrl_we && reg_wdata[CTRL_CLR_BIT];
  assign unused_wdata = ^{reg_wdata[31:N_KINDS], slot_take, slot_drop};

  always_ff @(posedge clk) begin
    if (!rst_n)       resp_en <= 1'b0;
    else if (ctrl_we) resp_en <= reg_wdata[CTRL_RESP_BIT];
  end

  cel_slot #(.AW(ADDR_W), .CW(CNT_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_vec),
    .ev_addr (ev_addr),
    .clr     (clr_pulse),
    .valid   (slot_valid),
    .kind    (slot_kind),
    .addr    (slot_addr),
    .cnt     (slot_cnt),
    .take    (slot_take),
    .drop    (slot_drop)
  );

  cel_pend u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev_vec),
    .w1c_we    (pend_we),
    .w1c_bits  (reg_wdata[N_KINDS-1:0]),
    .mask_we   (mask_we),
    .mask_bits (reg_wdata[N_KINDS-1:0]),
    .pend      (pend),
    .mask      (mask),
    .irq       (irq)
  );

  cel_match #(.AW(ADDR_W), .OFS(LINE_OFS)) u_match (
    .resp_en   (resp_en),
    .valid     (slot_valid),
    .slot_addr (slot_addr),
    .lk_addr   (lk_addr),
    .hit       (lk_hit)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_STATUS: begin
        reg_rdata[0]                 = slot_valid;
        reg_rdata[2:1]               = slot_kind;
        reg_rdata[CNT_LSB +: CNT_W]  = slot_cnt;
      end
      SEL_ADDR: reg_rdata            = 32'(slot_addr);
      SEL_PEND: reg_rdata            = 32'(pend);
      SEL_MASK: reg_rdata            = 32'(mask);
      SEL_CTRL: reg_rdata            = 32'(resp_en);
      default:  reg_rdata            = '0;
    endcase
  end
endmodule

// File: rtl/cache_err_log_chk.sv
module cache_err_log_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ev,
  input logic [AW-1:0] ev_addr,
  input logic          clr,
  input logic          valid,
  input logic [1:0]    kind,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] cnt,
  input logic [3:0]    pend,
  input logic [3:0]    mask,
  input logic          irq,
  input logic          hit,
  input logic          resp_en,
  input logic          drop
);
  a_r2_ue_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev[1] |=> (valid && kind == 2'd1 && addr == $past(ev_addr)));

  a_r3_sticky_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ev[1] && !clr) |=> (valid && $stable(addr) && $stable(kind)));

  a_r3_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (valid && !clr && !ev[1]));

  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev == 4'b0) |=> !valid);

  a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 4'b0) |=> ((pend & $past(ev)) == $past(ev)));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & mask) != 4'b0));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {CW{1'b1}} && !clr) |=> (cnt == {CW{1'b1}}));

  a_r9_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (valid && resp_en));
endmodule

bind cache_err_log cache_err_log_chk #(.AW(ADDR_W), .CW(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ev      (ev_vec),
  .ev_addr (ev_addr),
  .clr     (clr_pulse),
  .valid   (slot_valid),
  .kind    (slot_kind),
  .addr    (slot_addr),
  .cnt     (slot_cnt),
  .pend    (pend),
  .mask    (mask),
  .irq     (irq),
  .hit     (lk_hit),
  .resp_en (resp_en),
  .drop    (slot_drop)
);

// File: tb/cache_err_log_tb.sv
module cache_err_log_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_ce = 0, ev_ue = 0, ev_wp = 0, ev_be = 0;
  logic [31:0] ev_addr = '0;
  logic        reg_we = 0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state built from the requirements
  bit        m_valid;
  bit [1:0]  m_kind;
  bit [31:0] m_addr;
  int        m_cnt;
  bit [3:0]  m_pend, m_mask;
  bit        m_ren;

  always #5 clk = ~clk;

  cache_err_log u_dut (
    .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_wp(ev_wp),
    .ev_be(ev_be), .ev_addr(ev_addr), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .lk_addr(lk_addr), .lk_hit(lk_hit)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit [1:0] prio(input bit [3:0] e);
    if (e[1]) return 2'd1;
    if (e[0]) return 2'd0;
    if (e[2]) return 2'd2;
    return 2'd3;
  endfunction

  task automatic model(input bit [3:0] e, input bit [31:0] a, input bit we,
                       input bit [2:0] sel, input bit [31:0] wd);
    bit clr;
    clr = we && sel == 3'd4 && wd[1];
    if (we && sel == 3'd2) m_pend = m_pend & ~wd[3:0];
    m_pend = m_pend | e;
    if (we && sel == 3'd3) m_mask = wd[3:0];
    if (we && sel == 3'd4) m_ren = wd[0];
    if (e[1] || (e != 0 && (!m_valid || clr))) begin
      m_valid = 1; m_kind = prio(e); m_addr = a;
    end else if (clr) m_valid = 0;
    if (clr) m_cnt = e[0] ? 1 : 0;
    else if (e[0]) m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1;
  endtask

  task automatic cyc(input bit [3:0] e, input bit [31:0] a, input bit we,
                     input bit [2:0] sel, input bit [31:0] wd);
    @(negedge clk);
    {ev_be, ev_wp, ev_ue, ev_ce} = e;
    ev_addr = a; reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    model(e, a, we, sel, wd);
    @(negedge clk);
    {ev_be, ev_wp, ev_ue, ev_ce} = '0;
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(input bit [2:0] sel, output logic [31:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    rd(3'd0, v); chk(req, "STATUS", v, {16'b0, 8'(m_cnt), 5'b0, m_kind, m_valid});
    rd(3'd1, v); chk(req, "ADDR", v, m_addr);
    rd(3'd2, v); chk(req, "PEND", v, {28'b0, m_pend});
    rd(3'd3, v); chk("R7", "MASK", v, {28'b0, m_mask});
    chk("R7", "irq", {31'b0, irq}, {31'b0, |(m_pend & m_mask)});
  endtask

  task automatic clear_slot();
    cyc(4'b0, 32'h0, 1, 3'd4, {30'b0, 1'b1, m_ren});
  endtask

  task automatic clear_pend();
    cyc(4'b0, 32'h0, 1, 3'd2, 32'hF);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    m_valid = 1; m_kind = 2'd1; m_addr = 0; m_cnt = 0;
    m_pend = 0; m_mask = 0; m_ren = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check_all("R1");
    rd(3'd4, v); chk("R1", "CTRL", v, 32'h0);
    chk("R1", "lk_hit", {31'b0, lk_hit}, 32'h0);

    // R2 R3 R4: every event combination into an empty slot
    for (int e = 1; e < 16; e++) begin
      clear_slot(); clear_pend();
      cyc(4'(e), 32'h1000_0000 + 32'(e) * 32'h40, 0, 3'd0, 0);
      check_all("R4");
    end
    // R2 R3 R6: every combination into a slot already holding a correctable error
    for (int e = 1; e < 16; e++) begin
      clear_slot(); clear_pend();
      cyc(4'b0001, 32'h2000_0000, 0, 3'd0, 0);
      cyc(4'(e), 32'h3000_0000 + 32'(e) * 32'h80, 0, 3'd0, 0);
      check_all(e[1] ? "R2" : "R3");
    end
    // R5: clear alone, then clear with same-cycle events
    clear_slot(); check_all("R5");
    for (int e = 1; e < 16; e++) begin
      cyc(4'b0100, 32'h4000_0000, 0, 3'd0, 0);
      cyc(4'(e), 32'h5000_0000 + 32'(e), 1, 3'd4, 32'h2);
      check_all("R5");
    end
    // R6: write-1-clear versus same-cycle event, per bit
    for (int k = 0; k < 4; k++) begin
      cyc(4'hF, 32'h0, 0, 3'd0, 0);
      cyc(4'(1 << k), 32'h0, 1, 3'd2, 32'hF);
      check_all("R6");
    end
    // R7: sweep mask against pending patterns
    for (int p = 0; p < 16; p++) begin
      clear_pend();
      cyc(4'(p), 32'h600, 0, 3'd0, 0);
      for (int m = 0; m < 16; m++) begin
        cyc(4'b0, 32'h0, 1, 3'd3, 32'(m));
        chk("R7", "irq sweep", {31'b0, irq}, {31'b0, |(4'(p) & 4'(m))});
      end
    end
    // R8: counting, saturation and clear
    clear_slot();
    for (int i = 0; i < 260; i++) cyc(4'b0001, 32'h700, 0, 3'd0, 0);
    check_all("R8");
    cyc(4'b0001, 32'h700, 1, 3'd4, 32'h2);
    check_all("R8");
    clear_slot(); check_all("R8");

    // R9: line-granular lookup
    cyc(4'b0010, 32'h8000_1240, 1, 3'd4, 32'h1);
    for (int o = 0; o < 32; o++) begin
      lk_addr = 32'h8000_1240 + 32'(o); #1;
      chk("R9", "hit in line", {31'b0, lk_hit}, 32'h1);
    end
    lk_addr = 32'h8000_1260; #1; chk("R9", "next line", {31'b0, lk_hit}, 32'h0);
    lk_addr = 32'h8000_123F; #1; chk("R9", "prev line", {31'b0, lk_hit}, 32'h0);
    lk_addr = 32'h8000_1240;
    cyc(4'b0, 32'h0, 1, 3'd4, 32'h0);
    chk("R9", "disabled", {31'b0, lk_hit}, 32'h0);
    cyc(4'b0, 32'h0, 1, 3'd4, 32'h3);
    chk("R9", "slot empty", {31'b0, lk_hit}, 32'h0);
    rd(3'd4, v); chk("R9", "CTRL", v, 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule